// File: doc/BRIEF.md
# Cache Snoop Invalidation Unit

This unit watches a shared external bus while another master drives it. It removes lines from a small direct-mapped tag array when that master touches them, and it does so without any visible effect on the bus. A transfer is considered only when all of these hold: the bus clock enable is high, the transfer-start strobe is high, snoop enable is high, and the transfer kind is eligible. The unit takes the address at that bus edge and takes it again on the next core-clock edge. The two copies must agree. The unit then reads the tag and clears the line's valid bit on a hit. The read/write direction, the size and any dirty state of the line play no part in that decision. Nothing is written back.

The core side loads lines through a fill port and asks whether a line is present through a lookup port. When the two address captures disagree, the unit raises a sticky error flag and drops that snoop. Only reset clears the flag. If a snoop hit and a core fill land on the same index in the same cycle, the snoop wins, and the filled line is left invalid.

Top module: `snoop_inval_unit`

## Requirements
- R1: After synchronous reset every line is invalid: a lookup of any line address returns look_hit=0. cap_err is 0 after reset.
- R2: After a fill of line address L, a lookup of L returns look_hit=1, and look_dirty equals the dirty value given at the fill. A lookup of another line address with the same index (line address bits [5:0]) but a different tag returns look_hit=0.
- R3: A snoop of transfer kind 2'b00 (normal) to an address inside a valid line invalidates that line, whatever the xfer_rw and xfer_size values are.
- R4: A snoop of transfer kind 2'b01 (16-byte line move) to an address inside a valid line invalidates that line.
- R5: Transfers of kind 2'b10 or 2'b11 are ignored, and a line they address stays valid.
- R6: When snoop_en is low at the transfer start, no line is invalidated.
- R7: A line that was filled dirty is invalidated by a matching snoop just like a clean line. No write-back or bus output results.
- R8: A snoop whose tag differs from the stored tag at the same index leaves the line valid.
- R9: If bus_addr on the core edge after the start differs from bus_addr at the start, cap_err becomes 1 and no line is invalidated. cap_err stays 1 until reset, including across later good snoops.
- R10: When a snoop invalidation and a fill hit the same index on the same edge, the fill's tag is written but the line ends up invalid.
- R11: A transfer-start strobe seen while bclk_en is low starts no snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_en | input | 1 | Marks a core edge that is also a bus clock edge |
| xfer_start | input | 1 | Transfer-start strobe from the other master |
| snoop_en | input | 1 | Enables snooping of the current transfer |
| xfer_kind | input | 2 | Transfer kind: 00 normal, 01 line move, 10 and 11 other |
| xfer_rw | input | 1 | Transfer direction (does not affect invalidation) |
| xfer_size | input | 2 | Transfer size (does not affect invalidation) |
| bus_addr | input | 32 | Bus byte address |
| fill_en | input | 1 | Core fill strobe |
| fill_line | input | 28 | Line address to fill (byte address bits [31:4]) |
| fill_dirty | input | 1 | Dirty state recorded with the fill |
| look_line | input | 28 | Line address to look up |
| look_hit | output | 1 | Lookup result, two edges after look_line is presented |
| look_dirty | output | 1 | Dirty state of the hitting line, same timing |
| cap_err | output | 1 | Sticky flag: the two address captures disagreed |

## Verification
A valid bit that is wrongly cleared or wrongly kept shows up on look_hit. It appears on the second edge after a lookup is issued, and any lookup issued one edge after the snoop's second capture edge will see it. A capture-stage fault shows up on cap_err at the first core edge after the start, and the flag must then never drop. The priority fault, where the fill wins over the snoop, can only be seen by looking up the newly filled tag right after the colliding cycle.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  typedef enum logic [1:0] {
    XK_NORMAL   = 2'b00,
    XK_LINEMOVE = 2'b01,
    XK_ALTSPACE = 2'b10,
    XK_ACKCYC   = 2'b11
  } xfer_kind_e;

  function automatic logic kind_snoopable(input logic [1:0] k);
    xfer_kind_e kk;
    kk = xfer_kind_e'(k);
    return (kk == XK_NORMAL) || (kk == XK_LINEMOVE);
  endfunction

endpackage

// File: rtl/snoop_capture.sv
module snoop_capture #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bclk_en,
  input  logic                    xfer_start,
  input  logic                    snoop_en,
  input  logic [1:0]              xfer_kind,
  input  logic [ADDR_W-1:0]       bus_addr,
  output logic [ADDR_W-OFF_W-1:0] first_line,
  output logic                    chk_v,
  output logic [ADDR_W-OFF_W-1:0] chk_line,
  output logic                    cap_err
);
  import snoop_pkg::*;

  logic              s1_v;
  logic [ADDR_W-1:0] s1_addr;

  // First capture on the bus edge, second on the next core edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      chk_v   <= 1'b0;
      cap_err <= 1'b0;
    end else begin
      s1_v  <= bclk_en && xfer_start && snoop_en && kind_snoopable(xfer_kind);
      chk_v <= s1_v && (bus_addr == s1_addr);
      if (s1_v && (bus_addr != s1_addr)) cap_err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (bclk_en && xfer_start) s1_addr <= bus_addr;
    chk_line <= s1_addr[ADDR_W-1:OFF_W];
  end

  assign first_line = s1_addr[ADDR_W-1:OFF_W];
endmodule

// File: rtl/tag_ram.sv
module tag_ram #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 22
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  logic [TAG_W-1:0] w_tag,
  input  logic [IDX_W-1:0] a_idx,
  output logic [TAG_W-1:0] a_tag,
  input  logic [IDX_W-1:0] b_idx,
  output logic [TAG_W-1:0] b_tag
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] mem [DEPTH];

  // One write port, two synchronous read ports (read-first).
  always_ff @(posedge clk) begin
    if (we) mem[w_idx] <= w_tag;
    a_tag <= mem[a_idx];
    b_tag <= mem[b_idx];
  end
endmodule

// File: rtl/line_state.sv
module line_state #(
  parameter int IDX_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_en,
  input  logic [IDX_W-1:0]   set_idx,
  input  logic               set_dirty,
  input  logic               clr_en,
  input  logic [IDX_W-1:0]   clr_idx,
  output logic [(1<<IDX_W)-1:0] valid_o,
  output logic [(1<<IDX_W)-1:0] dirty_o
);
  localparam int LINES = 1 << IDX_W;

  // Clear beats set on a shared index.
  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_o[i] <= 1'b0;
        dirty_o[i] <= 1'b0;
      end else if (clr_en && (clr_idx == IDX_W'(i))) begin
        valid_o[i] <= 1'b0;
        dirty_o[i] <= 1'b0;
      end else if (set_en && (set_idx == IDX_W'(i))) begin
        valid_o[i] <= 1'b1;
        dirty_o[i] <= set_dirty;
      end
    end
  end
endmodule

// File: rtl/snoop_inval_unit.sv
module snoop_inval_unit #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int LINES      = 64,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = $clog2(LINES),
  localparam int LADDR_W   = ADDR_W - OFF_W,
  localparam int TAG_W     = LADDR_W - IDX_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bclk_en,
  input  logic               xfer_start,
  input  logic               snoop_en,
  input  logic [1:0]         xfer_kind,
  input  logic               xfer_rw,
  input  logic [1:0]         xfer_size,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               fill_en,
  input  logic [LADDR_W-1:0] fill_line,
  input  logic               fill_dirty,
  input  logic [LADDR_W-1:0] look_line,
  output logic               look_hit,
  output logic               look_dirty,
  output logic               cap_err
);
  logic [LADDR_W-1:0] first_line, chk_line;
  logic               chk_v;
  logic [TAG_W-1:0]   snp_tag_rd, lk_tag_rd;
  logic [LINES-1:0]   valid_w, dirty_w;
  logic               inval_fire;
  logic [IDX_W-1:0]   chk_idx;

  snoop_capture #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_cap (
    .clk(clk), .rst(rst), .bclk_en(bclk_en), .xfer_start(xfer_start),
    .snoop_en(snoop_en), .xfer_kind(xfer_kind), .bus_addr(bus_addr),
    .first_line(first_line), .chk_v(chk_v), .chk_line(chk_line),
    .cap_err(cap_err)
  );

  tag_ram #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .we(fill_en),
    .w_idx(fill_line[IDX_W-1:0]), .w_tag(fill_line[LADDR_W-1:IDX_W]),
    .a_idx(first_line[IDX_W-1:0]), .a_tag(snp_tag_rd),
    .b_idx(look_line[IDX_W-1:0]),  .b_tag(lk_tag_rd)
  );

  assign chk_idx    = chk_line[IDX_W-1:0];
  assign inval_fire = chk_v && valid_w[chk_idx] &&
                      (snp_tag_rd == chk_line[LADDR_W-1:IDX_W]);

  line_state #(.IDX_W(IDX_W)) u_state (
    .clk(clk), .rst(rst),
    .set_en(fill_en), .set_idx(fill_line[IDX_W-1:0]), .set_dirty(fill_dirty),
    .clr_en(inval_fire), .clr_idx(chk_idx),
    .valid_o(valid_w), .dirty_o(dirty_w)
  );

  // Core lookup: state sampled on the first edge, compared on the second.
  logic             lk_v_q, lk_d_q;
  logic [TAG_W-1:0] lk_tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_v_q     <= 1'b0;
      lk_d_q     <= 1'b0;
      look_hit   <= 1'b0;
      look_dirty <= 1'b0;
    end else begin
      lk_v_q     <= valid_w[look_line[IDX_W-1:0]];
      lk_d_q     <= dirty_w[look_line[IDX_W-1:0]];
      look_hit   <= lk_v_q && (lk_tag_rd == lk_tag_q);
      look_dirty <= lk_v_q && lk_d_q && (lk_tag_rd == lk_tag_q);
    end
  end

  always_ff @(posedge clk) lk_tag_q <= look_line[LADDR_W-1:IDX_W];
endmodule

// File: rtl/snoop_inval_chk.sv
module snoop_inval_chk (
  input logic       clk,
  input logic       rst,
  input logic       bclk_en,
  input logic       xfer_start,
  input logic       snoop_en,
  input logic [1:0] xfer_kind,
  input logic       xfer_rw,
  input logic [1:0] xfer_size,
  input logic       look_hit,
  input logic       look_dirty,
  input logic       cap_err,
  input logic       inval_fire
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!cap_err && !look_hit));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    cap_err |=> cap_err);

  a_r9_err_blocks_inval: assert property (@(posedge clk) disable iff (rst)
    $rose(cap_err) |-> !inval_fire);

  a_r6_enable_gate: assert property (@(posedge clk) disable iff (rst)
    inval_fire |-> ($past(snoop_en, 2) && $past(xfer_start, 2)));

  a_r11_bus_edge_gate: assert property (@(posedge clk) disable iff (rst)
    inval_fire |-> $past(bclk_en, 2));

  a_r5_kind_gate: assert property (@(posedge clk) disable iff (rst)
    inval_fire |-> ($past(xfer_kind, 2) == 2'b00 || $past(xfer_kind, 2) == 2'b01));

  a_r2_dirty_needs_hit: assert property (@(posedge clk) disable iff (rst)
    look_dirty |-> look_hit);

  always @(posedge clk) begin
    if (!rst && xfer_start)
      a_r3_attr_defined: assert (!$isunknown({xfer_rw, xfer_size}));
  end
endmodule

bind snoop_inval_unit snoop_inval_chk u_chk (
  .clk(clk), .rst(rst), .bclk_en(bclk_en), .xfer_start(xfer_start),
  .snoop_en(snoop_en), .xfer_kind(xfer_kind), .xfer_rw(xfer_rw),
  .xfer_size(xfer_size), .look_hit(look_hit), .look_dirty(look_dirty),
  .cap_err(cap_err), .inval_fire(inval_fire)
);

// File: tb/snoop_inval_unit_test.sv
module snoop_inval_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk_en = 1'b0, xfer_start = 1'b0, snoop_en = 1'b0;
  logic [1:0]  xfer_kind = 2'b00, xfer_size = 2'b00;
  logic        xfer_rw = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        fill_en = 1'b0, fill_dirty = 1'b0;
  logic [27:0] fill_line = '0, look_line = '0;
  logic        look_hit, look_dirty, cap_err;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  snoop_inval_unit uut (
    .clk(clk), .rst(rst), .bclk_en(bclk_en), .xfer_start(xfer_start),
    .snoop_en(snoop_en), .xfer_kind(xfer_kind), .xfer_rw(xfer_rw),
    .xfer_size(xfer_size), .bus_addr(bus_addr), .fill_en(fill_en),
    .fill_line(fill_line), .fill_dirty(fill_dirty), .look_line(look_line),
    .look_hit(look_hit), .look_dirty(look_dirty), .cap_err(cap_err)
  );

  // Lines: L1 and L1_ALIAS share index 5; LP and LP2 share index 0x33.
  localparam logic [27:0] L1       = 28'h0000105;
  localparam logic [27:0] L1_ALIAS = 28'h0000145;
  localparam logic [27:0] L2       = 28'h0ABCDE7;
  localparam logic [27:0] L3       = 28'h0F00010;
  localparam logic [27:0] LP       = 28'h0000033;
  localparam logic [27:0] LP2      = 28'h0000073;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  task automatic fill(input logic [27:0] ln, input logic d);
    fill_en = 1'b1; fill_line = ln; fill_dirty = d;
    tick();
    fill_en = 1'b0;
  endtask

  task automatic lookup(input logic [27:0] ln, input string req,
                        input int exp_hit, input int exp_dirty);
    look_line = ln;
    tick();
    tick();
    check(req, "look_hit", int'(look_hit), exp_hit);
    if (exp_hit == 1) check(req, "look_dirty", int'(look_dirty), exp_dirty);
  endtask

  // Snoop: start edge, second capture edge, invalidate edge.
  task automatic snoop(input logic [31:0] a, input logic [1:0] k, input logic rw,
                       input logic [1:0] sz, input logic en, input logic be,
                       input logic [31:0] a2, input logic do_fill,
                       input logic [27:0] fl);
    bus_addr = a; xfer_kind = k; xfer_rw = rw; xfer_size = sz;
    snoop_en = en; bclk_en = be; xfer_start = 1'b1;
    tick();
    xfer_start = 1'b0; bclk_en = 1'b0; bus_addr = a2;
    tick();
    if (do_fill) begin fill_en = 1'b1; fill_line = fl; fill_dirty = 1'b0; end
    tick();
    fill_en = 1'b0; snoop_en = 1'b0;
  endtask

  task automatic t_reset();
    lookup(L1, "R1", 0, 0);
    check("R1", "cap_err", int'(cap_err), 0);
  endtask

  task automatic t_fill_lookup();
    fill(L1, 1'b0);
    fill(L2, 1'b1);
    lookup(L1, "R2", 1, 0);
    lookup(L2, "R2", 1, 1);
    lookup(L1_ALIAS, "R2", 0, 0);
  endtask

  task automatic t_normal();
    snoop({L1, 4'h8}, 2'b00, 1'b1, 2'b10, 1'b1, 1'b1, {L1, 4'h8}, 1'b0, '0);
    lookup(L1, "R3", 0, 0);
    fill(L1, 1'b0);
    snoop({L1, 4'h0}, 2'b00, 1'b0, 2'b01, 1'b1, 1'b1, {L1, 4'h0}, 1'b0, '0);
    lookup(L1, "R3", 0, 0);
  endtask

  task automatic t_linemove_dirty();
    snoop({L2, 4'h0}, 2'b01, 1'b0, 2'b11, 1'b1, 1'b1, {L2, 4'h0}, 1'b0, '0);
    lookup(L2, "R4", 0, 0);
    fill(L3, 1'b1);
    lookup(L3, "R7", 1, 1);
    snoop({L3, 4'hC}, 2'b00, 1'b1, 2'b00, 1'b1, 1'b1, {L3, 4'hC}, 1'b0, '0);
    lookup(L3, "R7", 0, 0);
  endtask

  task automatic t_ignored();
    fill(L1, 1'b0);
    snoop({L1, 4'h4}, 2'b10, 1'b0, 2'b10, 1'b1, 1'b1, {L1, 4'h4}, 1'b0, '0);
    lookup(L1, "R5", 1, 0);
    snoop({L1, 4'h4}, 2'b11, 1'b1, 2'b10, 1'b1, 1'b1, {L1, 4'h4}, 1'b0, '0);
    lookup(L1, "R5", 1, 0);
    snoop({L1, 4'h4}, 2'b00, 1'b1, 2'b10, 1'b0, 1'b1, {L1, 4'h4}, 1'b0, '0);
    lookup(L1, "R6", 1, 0);
    snoop({L1_ALIAS, 4'h4}, 2'b00, 1'b1, 2'b10, 1'b1, 1'b1, {L1_ALIAS, 4'h4}, 1'b0, '0);
    lookup(L1, "R8", 1, 0);
    snoop({L1, 4'h4}, 2'b00, 1'b1, 2'b10, 1'b1, 1'b0, {L1, 4'h4}, 1'b0, '0);
    lookup(L1, "R11", 1, 0);
  endtask

  task automatic t_mismatch();
    check("R9", "cap_err before", int'(cap_err), 0);
    snoop({L1, 4'h4}, 2'b00, 1'b0, 2'b10, 1'b1, 1'b1, {L1, 4'h4} ^ 32'h0000_0100, 1'b0, '0);
    check("R9", "cap_err after", int'(cap_err), 1);
    lookup(L1, "R9", 1, 0);
    snoop({L1, 4'h4}, 2'b00, 1'b0, 2'b10, 1'b1, 1'b1, {L1, 4'h4}, 1'b0, '0);
    lookup(L1, "R3", 0, 0);
    check("R9", "cap_err sticky", int'(cap_err), 1);
    do_reset();
    check("R1", "cap_err after reset", int'(cap_err), 0);
    lookup(L2, "R1", 0, 0);
  endtask

  task automatic t_priority();
    fill(LP, 1'b0);
    lookup(LP, "R10", 1, 0);
    snoop({LP, 4'h0}, 2'b00, 1'b0, 2'b10, 1'b1, 1'b1, {LP, 4'h0}, 1'b1, LP2);
    lookup(LP2, "R10", 0, 0);
    lookup(LP, "R10", 0, 0);
  endtask

  bit done = 1'b0;

  initial begin
    do_reset();
    t_reset();
    t_fill_lookup();
    t_normal();
    t_linemove_dirty();
    t_ignored();
    t_mismatch();
    t_priority();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule